// File: doc/BRIEF.md
# Hilbert Analytic-Signal Generator

This block turns a stream of real, signed samples into an analytic signal. Each output is a pair: an in-phase value and a quadrature value. A downstream phase detector uses the pair to compute the angle. The quadrature path is a fixed 11-tap FIR Hilbert filter. The in-phase path is a plain delay line, matched to the five-sample group delay of the filter, so both outputs stay aligned in time.

The filter is odd-symmetric about its centre tap, and every even-offset coefficient is zero. Only the offset pairs ±1, ±3 and ±5 take part. For each pair, the older sample minus the newer sample is formed first, then one constant multiply is applied, so the filter uses three multiplies in all. The coefficients are fixed Q14 constants: 2/(πn) with a Hamming window applied. The full-width sum is rounded and then saturated to the sample width.

A two-state controller gates the output strobe. In state FILL_S it counts accepted samples. When the eleventh sample is accepted, the FILL_S→RUN_S transition is taken, because the delay line now holds only real data. In state RUN_S the controller stays put until reset, and every accepted sample yields one output pair. An output pair appears two clock edges after its sample is accepted: the first edge shifts the delay line, the second registers the outputs.

Top module: `hilbert_iq_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and both `out_i` and `out_q` are 0.
- R2: `out_valid` stays 0 until eleven samples have been accepted since reset. A sample is accepted when `in_valid` is 1 at a rising edge.
- R3: Once eleven samples have been accepted, each further accepted sample makes `out_valid` high for exactly one cycle, two rising edges after acceptance. `out_valid` is 0 in every other cycle.
- R4: With each strobe, `out_i` equals the sample accepted five acceptances before the newest one.
- R5: With each strobe, `out_q` equals Σ c(m)·(x[k−5−m] − x[k−5+m]) / 2^14 over m ∈ {1,3,5}, with c(1)=9513, c(3)=1383, c(5)=167. Here x[k] is the newest accepted sample. The centre sample and the even offsets add nothing.
- R6: The division by 2^14 rounds half upward: 2^13 is added, then the result is floored. For example, +4756.5 gives 4757 and −4756.5 gives −4756.
- R7: A quadrature result above 2^(W−1)−1 or below −2^(W−1) is clamped to that limit, where W is the sample width `DATA_W`.
- R8: Cycles with `in_valid` low change neither the delay line nor the outputs. `out_i` and `out_q` hold their values, and a gapped stream gives the same pairs as an unbroken one.
- R9: After a single impulse of amplitude A, the successive quadrature outputs are antisymmetric in time: −c5, 0, −c3, 0, −c1, 0, +c1, 0, +c3, 0, +c5, each multiplied by A/2^14 and rounded as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Signed real input sample |
| out_valid | output | 1 | Output pair strobe |
| out_i | output | DATA_W | In-phase output, the input delayed to the filter centre |
| out_q | output | DATA_W | Quadrature output, the Hilbert-filtered sample |

## Verification
The assertions assume `in_valid` is low while `rst` is high. They also assume that `in_data` matters only in cycles where `in_valid` is high. The input may pause for any number of cycles and then resume. The stimulus holds `in_valid` at 0 throughout both reset pulses and drives `in_data` only through the sample task. It mixes back-to-back runs, single and multiple gaps, impulses, ramps, a sinusoid and a full-scale square wave, so every strobe and hold relation is exercised under both steady and interrupted input.

// File: rtl/hilb_pkg.sv
package hilb_pkg;

    // Filter geometry: odd length, centre tap at the group delay
    localparam int TAPS      = 11;
    localparam int CENTRE    = (TAPS - 1) / 2;
    localparam int PAIRS     = (TAPS + 1) / 4;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;

    // Windowed 2/(pi*n) for odd offsets n = 2p+1, Q14
    function automatic logic signed [COEF_W-1:0] pair_coef(input int p);
        case (p)
            0:       pair_coef = 16'sd9513;
            1:       pair_coef = 16'sd1383;
            2:       pair_coef = 16'sd167;
            default: pair_coef = 16'sd0;
        endcase
    endfunction

    typedef enum logic [0:0] {
        FILL_S = 1'b0,
        RUN_S  = 1'b1
    } fill_state_e;

endpackage

// File: rtl/hilb_tap_line.sv
module hilb_tap_line
    import hilb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          shift,
    input  logic [DATA_W-1:0]             din,
    output logic [PAIRS-1:0][DATA_W-1:0]  pair_new,
    output logic [PAIRS-1:0][DATA_W-1:0]  pair_old,
    output logic [DATA_W-1:0]             centre
);

    // index 0 holds the newest accepted sample
    logic [TAPS-1:0][DATA_W-1:0] line;

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= '0;
        end else if (shift) begin
            line <= {line[TAPS-2:0], din};
        end
    end

    generate
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            localparam int OFF = 2 * p + 1;
            assign pair_new[p] = line[CENTRE - OFF];
            assign pair_old[p] = line[CENTRE + OFF];
        end
    endgenerate

    assign centre = line[CENTRE];

endmodule

// File: rtl/hilb_pair_mac.sv
module hilb_pair_mac
    import hilb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = DATA_W + COEF_W + 3
) (
    input  logic [PAIRS-1:0][DATA_W-1:0] pair_new,
    input  logic [PAIRS-1:0][DATA_W-1:0] pair_old,
    output logic signed [ACC_W-1:0]      acc
);

    localparam int DIFF_W = DATA_W + 1;
    localparam int PROD_W = DIFF_W + COEF_W;

    logic signed [PROD_W-1:0] prod [PAIRS];

    // one multiply per antisymmetric pair: (older - newer) * c
    generate
        for (genvar p = 0; p < PAIRS; p++) begin : g_mul
            logic signed [DIFF_W-1:0] diff;
            assign diff = $signed({pair_old[p][DATA_W-1], pair_old[p]})
                        - $signed({pair_new[p][DATA_W-1], pair_new[p]});
            assign prod[p] = PROD_W'(diff) * PROD_W'(pair_coef(p));
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int p = 0; p < PAIRS; p++) begin
            acc = acc + ACC_W'(prod[p]);
        end
    end

endmodule

// File: rtl/hilb_round_sat.sv
module hilb_round_sat #(
    parameter int IN_W  = 35,
    parameter int FRAC  = 14,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);

    localparam int W = IN_W + 1;
    localparam logic signed [W-1:0] HALF =
        {{(W - FRAC){1'b0}}, 1'b1, {(FRAC - 1){1'b0}}};
    localparam logic signed [W-1:0] MAXV = W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [W-1:0] MINV = -MAXV - W'(1);

    logic signed [W-1:0] biased;
    logic signed [W-1:0] shifted;

    always_comb begin
        biased  = $signed({din[IN_W-1], din}) + HALF;
        shifted = biased >>> FRAC;
        if (shifted > MAXV) begin
            dout = MAXV[OUT_W-1:0];
        end else if (shifted < MINV) begin
            dout = MINV[OUT_W-1:0];
        end else begin
            dout = shifted[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/hilb_fill_ctrl.sv
module hilb_fill_ctrl
    import hilb_pkg::*;
#(
    parameter int FILL_N = TAPS
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    output logic window_full
);

    localparam int CNT_W = $clog2(FILL_N + 1);

    fill_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FILL_S;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FILL_S: begin
                if (accept) begin
                    if (cnt_q == CNT_W'(FILL_N - 1)) begin
                        state_d = RUN_S;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            RUN_S: begin
                state_d = RUN_S;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FILL_S: window_full = 1'b0;
            RUN_S:  window_full = 1'b1;
        endcase
    end

endmodule

// File: rtl/hilbert_iq_gen.sv
module hilbert_iq_gen
    import hilb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q
);

    localparam int ACC_W = DATA_W + 1 + COEF_W + $clog2(PAIRS) + 1;

    logic [PAIRS-1:0][DATA_W-1:0] pair_new;
    logic [PAIRS-1:0][DATA_W-1:0] pair_old;
    logic [DATA_W-1:0]            centre;
    logic signed [ACC_W-1:0]      acc;
    logic signed [DATA_W-1:0]     q_rnd;
    logic                         window_full;
    logic                         stage_vld;

    hilb_tap_line #(.DATA_W(DATA_W)) u_line (
        .clk      (clk),
        .rst      (rst),
        .shift    (in_valid),
        .din      (in_data),
        .pair_new (pair_new),
        .pair_old (pair_old),
        .centre   (centre)
    );

    hilb_pair_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
        .pair_new (pair_new),
        .pair_old (pair_old),
        .acc      (acc)
    );

    hilb_round_sat #(.IN_W(ACC_W), .FRAC(COEF_FRAC), .OUT_W(DATA_W)) u_rnd (
        .din  (acc),
        .dout (q_rnd)
    );

    hilb_fill_ctrl #(.FILL_N(TAPS)) u_fill (
        .clk         (clk),
        .rst         (rst),
        .accept      (in_valid),
        .window_full (window_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_vld <= 1'b0;
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            stage_vld <= in_valid;
            out_valid <= stage_vld && window_full;
            if (stage_vld) begin
                out_i <= $signed(centre);
                out_q <= q_rnd;
            end
        end
    end

endmodule

// File: rtl/hilb_iq_gen_chk.sv
module hilb_iq_gen_chk #(
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_data,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_i,
    input logic signed [DATA_W-1:0] out_q
);

    logic                   vld_d1, vld_d2, full_d;
    logic [3:0]             seen;
    logic [5:0][DATA_W-1:0] hist;
    logic [DATA_W-1:0]      hist5_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_d1  <= 1'b0;
            vld_d2  <= 1'b0;
            full_d  <= 1'b0;
            seen    <= '0;
            hist    <= '0;
            hist5_d <= '0;
        end else begin
            vld_d1  <= in_valid;
            vld_d2  <= vld_d1;
            full_d  <= (seen >= 4'd11);
            hist5_d <= hist[5];
            if (in_valid) begin
                hist <= {hist[4:0], in_data};
                if (seen != 4'd15) seen <= seen + 4'd1;
            end
        end
    end

    // R2: strobe stays low while the window still holds reset zeros
    p_fill_gate_r2: assert property (@(posedge clk) disable iff (rst)
        !full_d |-> !out_valid);

    // R3: exactly one strobe, two edges after each accepted sample
    p_valid_timing_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid == (vld_d2 && full_d));

    // R4: in-phase output is the sample five acceptances back
    p_centre_tap_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_i == $signed(hist5_d)));

    // R8: no acceptance, no change at the outputs
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !vld_d2 |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind hilbert_iq_gen hilb_iq_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/sim_hilbert_iq_gen.sv
module sim_hilbert_iq_gen;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic          out_valid;
    logic signed [DW-1:0] out_i, out_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hilbert_iq_gen #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // behavioural reference model
    int    hist[$];
    int    count;
    bit    pend_vld, pend_full;
    int    pend_i, pend_q;
    string pend_tag;
    bit    exp_valid;
    int    exp_i, exp_q;
    string exp_tag;
    bit    exp_upd;
    string q_phase;

    function automatic int coef(int m);
        if (m == 1) return 9513;
        if (m == 3) return 1383;
        return 167;
    endfunction

    task automatic model_reset();
        hist.delete();
        count = 0; pend_vld = 0; pend_full = 0; pend_i = 0; pend_q = 0;
        exp_valid = 0; exp_i = 0; exp_q = 0; exp_upd = 0;
        pend_tag = "R1"; exp_tag = "R1";
    endtask

    task automatic model_edge(bit v, int d);
        longint acc;
        longint r;
        exp_upd = pend_vld;
        exp_valid = pend_vld && pend_full;
        if (pend_vld) begin
            exp_i = pend_i; exp_q = pend_q; exp_tag = pend_tag;
        end
        pend_vld = v;
        if (v) begin
            hist.push_front(d);
            if (hist.size() > 11) void'(hist.pop_back());
            count++;
            pend_full = (count >= 11);
            while (hist.size() < 11) hist.push_back(0);
            pend_i = hist[5];
            acc = 0;
            for (int m = 1; m <= 5; m += 2)
                acc += longint'(coef(m)) * (hist[5 + m] - hist[5 - m]);
            r = (acc + 8192) >>> 14;
            pend_tag = q_phase;
            if ((acc & 16383) == 8192) pend_tag = "R6";
            if (r > 32767) begin r = 32767; pend_tag = "R7"; end
            if (r < -32768) begin r = -32768; pend_tag = "R7"; end
            pend_q = int'(r);
        end
    endtask

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        string vt;
        vt = (count < 11) ? "R2" : "R3";
        check(out_valid == exp_valid, vt, "out_valid", int'(out_valid), int'(exp_valid));
        check(out_i == exp_i, exp_upd ? "R4" : "R8", "out_i", int'(out_i), exp_i);
        check(out_q == exp_q, exp_upd ? exp_tag : "R8", "out_q", int'(out_q), exp_q);
    endtask

    task automatic step(bit v, int d);
        in_valid = v;
        in_data  = DW'(d);
        @(posedge clk);
        model_edge(v, d);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        in_valid = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_i == 0 && out_q == 0, "R1", "reset outputs",
              int'(out_valid) + int'(out_i) + int'(out_q), 0);
        rst = 0;
        model_reset();
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 0 && out_i == 0 && out_q == 0, "R1", "after reset",
              int'(out_valid) + int'(out_i) + int'(out_q), 0);
    endtask

    initial begin
        q_phase = "R5";
        model_reset();
        do_reset();

        // fill with a ramp, then run on (R2, R3, R4, R5)
        for (int k = 0; k < 20; k++) step(1, 300 * k - 2000);
        // idle cycles hold the outputs (R8)
        for (int k = 0; k < 4; k++) step(0, 12345);

        // positive and negative impulses (R9, R6 on the half-way products)
        q_phase = "R9";
        for (int k = 0; k < 12; k++) step(1, 0);
        step(1, 8192);
        for (int k = 0; k < 12; k++) step(1, 0);
        step(1, -8192);
        for (int k = 0; k < 12; k++) step(1, 0);

        // gapped sinusoid (R5, R8)
        q_phase = "R5";
        for (int k = 0; k < 90; k++) begin
            if (k % 3 == 2) step(0, -777);
            else step(1, $rtoi(20000.0 * $cos(0.7 * k)));
        end

        // full-scale square wave drives the clamp (R7)
        for (int k = 0; k < 48; k++) step(1, ((k / 6) % 2 == 0) ? 32767 : -32768);
        for (int k = 0; k < 3; k++) step(0, 0);

        // second reset, refill (R1, R2)
        do_reset();
        for (int k = 0; k < 14; k++) step(1, 1000 - 150 * k);
        step(0, 0);
        step(0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule